// File: doc/BRIEF.md
# Privileged Exception Entry and Return Sequencer

This block steers the program counter when a processor core takes an exception or comes back from one. When a fault is posted, it picks a vector offset for that fault kind and adds it to a programmable privileged-code base. It records a restart address and enters privileged mode, which also selects the shadow register bank. Whether the restart address is written, and what value it gets, depends on the fault kind and on the mode the core was in. When a return is requested, the saved address becomes the new PC. Bit 0 of that address decides whether the core stays privileged and keeps the shadow bank, or drops back to the normal bank.

Every event takes effect on the clock edge that samples it. The redirect target appears on `npc` with the sequential successor on `nnpc`, and `redir_vld` is high for one cycle. After reset is released, the first clock always performs a reset-vector redirect. A return requested outside privileged mode is not honoured. It is turned into an unimplemented-opcode fault entry. A successful return raises a one-cycle request to re-evaluate pending interrupts.

Top module: `trap_sequencer`

## Requirements
- R1: While `rst_n` is low, `shadow_sel`=1, `redir_vld`=0, `irq_recheck`=0, `exc_addr`=0 and `npc`=0. The first clock after release redirects to `pal_base`+0x0001 and keeps `shadow_sel`=1.
- R2: An accepted fault redirects `npc` to `pal_base` plus the offset for `fault_kind`. The kinds are 1 reset→0x0001, 2 machine check→0x0401, 3 alignment→0x0301, 4 interrupt→0x0101, 5 privileged call→0x2001, 6 translation miss→0x0201 and 7 unimplemented opcode→0x0501. `redir_vld` is high for exactly the one cycle after each accepted event.
- R3: On a fault-class entry (any kind except 4 and 5), `exc_addr` becomes `cur_pc` with bit 0 replaced by the privilege state at entry.
- R4: On a privileged-call entry (kind 5), `exc_addr` is that same value plus 4.
- R5: An interrupt (kind 4) taken in privileged mode leaves `exc_addr` unchanged. An interrupt taken in user mode saves it as in R3.
- R6: Every entry leaves `shadow_sel`=1.
- R7: On every redirect, `nnpc` equals `npc`+4.
- R8: A return in privileged mode sets `npc` to `exc_addr` and leaves `exc_addr` unchanged. It clears `shadow_sel` only when bit 0 of `exc_addr` is 0, and pulses `irq_recheck` for one cycle.
- R9: A return requested in user mode makes an unimplemented-opcode entry (offset 0x0501) that saves `cur_pc` as in R3, and it does not pulse `irq_recheck`.
- R10: When a fault and a return are requested in the same cycle, the fault is taken and the return is discarded.
- R11: `fault_req` with `fault_kind`=0 has no effect on `npc`, `redir_vld`, `exc_addr` or `shadow_sel`.
- R12: A bank swap is only ever requested toward the bank that is not active. An entry made while privileged keeps `shadow_sel`=1 without a swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_base | input | ADDR_W | Base address of privileged handler code |
| cur_pc | input | ADDR_W | PC of the instruction being faulted or returning |
| fault_req | input | 1 | Fault posted this cycle |
| fault_kind | input | 3 | Fault kind code (see R2) |
| eret_req | input | 1 | Return-from-exception request |
| npc | output | ADDR_W | Redirected PC |
| nnpc | output | ADDR_W | Successor of the redirected PC |
| redir_vld | output | 1 | One-cycle strobe marking a new redirect |
| shadow_sel | output | 1 | Shadow bank selected / privileged mode |
| exc_addr | output | ADDR_W | Saved restart address |
| irq_recheck | output | 1 | One-cycle pulse after a successful return |

## Verification
The directed sequence moves between modes so that each save rule is exercised from both privileged and user mode. A design that always saved on interrupts would overwrite the restart address of a nested handler. One that skipped the +4 on privileged calls would re-execute the call forever. Returns are made to addresses with bit 0 both set and clear, which catches a design that leaves the shadow bank unconditionally. A return from user mode, a fault colliding with a return, and a fault request with kind 0 show up as a missing unimplemented-opcode vector, a spurious recheck pulse, or a redirect that should never have happened.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  typedef enum logic [2:0] {
    FK_NONE    = 3'd0,
    FK_RESET   = 3'd1,
    FK_MCHK    = 3'd2,
    FK_ALIGN   = 3'd3,
    FK_INTR    = 3'd4,
    FK_PALCALL = 3'd5,
    FK_XMISS   = 3'd6,
    FK_ILLOP   = 3'd7
  } fault_kind_e;

  localparam int VOFF_W = 16;

  localparam logic [VOFF_W-1:0] VOFF_NONE    = 16'h0000;
  localparam logic [VOFF_W-1:0] VOFF_RESET   = 16'h0001;
  localparam logic [VOFF_W-1:0] VOFF_MCHK    = 16'h0401;
  localparam logic [VOFF_W-1:0] VOFF_ALIGN   = 16'h0301;
  localparam logic [VOFF_W-1:0] VOFF_INTR    = 16'h0101;
  localparam logic [VOFF_W-1:0] VOFF_PALCALL = 16'h2001;
  localparam logic [VOFF_W-1:0] VOFF_XMISS   = 16'h0201;
  localparam logic [VOFF_W-1:0] VOFF_ILLOP   = 16'h0501;

  // Byte distance from one instruction to the next
  localparam int INSN_BYTES = 4;

endpackage

// File: rtl/trap_vec_lut.sv
module trap_vec_lut
  import trap_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  fault_kind_e        kind,
  output logic [ADDR_W-1:0]  offset
);

  localparam int PAD_W = ADDR_W - VOFF_W;

  logic [VOFF_W-1:0] off_raw;

  always_comb begin
    unique case (kind)
      FK_RESET:   off_raw = VOFF_RESET;
      FK_MCHK:    off_raw = VOFF_MCHK;
      FK_ALIGN:   off_raw = VOFF_ALIGN;
      FK_INTR:    off_raw = VOFF_INTR;
      FK_PALCALL: off_raw = VOFF_PALCALL;
      FK_XMISS:   off_raw = VOFF_XMISS;
      FK_ILLOP:   off_raw = VOFF_ILLOP;
      default:    off_raw = VOFF_NONE;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign offset = {{PAD_W{1'b0}}, off_raw};
    end else begin : g_nopad
      assign offset = off_raw[ADDR_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/trap_save_calc.sv
module trap_save_calc
  import trap_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               enter,
  input  fault_kind_e        kind,
  input  logic [ADDR_W-1:0]  cur_pc,
  input  logic               priv,
  output logic               save_en,
  output logic [ADDR_W-1:0]  save_val
);

  localparam logic [ADDR_W-1:0] LSB_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] tagged_pc;
  logic              nested_intr;
  logic              skip_insn;

  always_comb begin
    tagged_pc   = (cur_pc & LSB_MASK) | {{(ADDR_W-1){1'b0}}, priv};
    nested_intr = (kind == FK_INTR) && priv;
    skip_insn   = (kind == FK_PALCALL);
    save_en     = enter && !nested_intr;
    save_val    = skip_insn ? (tagged_pc + STEP) : tagged_pc;
  end

endmodule

// File: rtl/trap_mode_ctl.sv
module trap_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  output logic shadow_q
);

  logic swap_go;
  logic swap_to;
  logic shadow_d;

  always_comb begin
    swap_go  = (enter && !shadow_q) || (leave && !enter);
    swap_to  = enter;
    shadow_d = swap_go ? swap_to : shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= 1'b1;
    end else if (swap_go) begin
      shadow_q <= shadow_d;
    end
  end

  AST_SWAP_TOWARD_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    swap_go |-> (swap_to != shadow_q)); // R12

  AST_ENTER_SELECTS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> shadow_q); // R6

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pal_base,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              fault_req,
  input  logic [2:0]        fault_kind,
  input  logic              eret_req,
  output logic [ADDR_W-1:0] npc,
  output logic [ADDR_W-1:0] nnpc,
  output logic              redir_vld,
  output logic              shadow_sel,
  output logic [ADDR_W-1:0] exc_addr,
  output logic              irq_recheck
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  fault_kind_e       req_kind;
  fault_kind_e       ent_kind;
  logic              boot_q;
  logic              ent_take;
  logic              ret_take;
  logic              ret_ok;
  logic              ret_bad;
  logic              any_entry;
  logic              leave;
  logic              redir_d;
  logic              save_en;
  logic [ADDR_W-1:0] save_val;
  logic [ADDR_W-1:0] vec_off;
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] npc_q;
  logic [ADDR_W-1:0] nnpc_q;
  logic [ADDR_W-1:0] exc_q;
  logic              redir_q;
  logic              recheck_q;
  logic              priv;

  // Arbitration: boot redirect, then fault, then return
  always_comb begin
    req_kind  = fault_kind_e'(fault_kind);
    ent_take  = !boot_q && fault_req && (req_kind != FK_NONE);
    ret_take  = !boot_q && !ent_take && eret_req;
    ret_ok    = ret_take && priv;
    ret_bad   = ret_take && !priv;
    any_entry = boot_q || ent_take || ret_bad;
    leave     = ret_ok && !exc_q[0];
    if (boot_q) begin
      ent_kind = FK_RESET;
    end else if (ret_bad) begin
      ent_kind = FK_ILLOP;
    end else begin
      ent_kind = req_kind;
    end
  end

  trap_vec_lut #(.ADDR_W(ADDR_W)) u_vec (
    .kind   (ent_kind),
    .offset (vec_off)
  );

  trap_save_calc #(.ADDR_W(ADDR_W)) u_save (
    .enter    (ent_take || ret_bad),
    .kind     (ent_kind),
    .cur_pc   (cur_pc),
    .priv     (priv),
    .save_en  (save_en),
    .save_val (save_val)
  );

  trap_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter    (any_entry),
    .leave    (leave),
    .shadow_q (priv)
  );

  always_comb begin
    tgt     = any_entry ? (pal_base + vec_off) : exc_q;
    redir_d = any_entry || ret_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q    <= 1'b1;
      redir_q   <= 1'b0;
      recheck_q <= 1'b0;
    end else begin
      boot_q    <= 1'b0;
      redir_q   <= redir_d;
      recheck_q <= ret_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc_q  <= '0;
      nnpc_q <= '0;
    end else if (redir_d) begin
      npc_q  <= tgt;
      nnpc_q <= tgt + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q <= '0;
    end else if (save_en) begin
      exc_q <= save_val;
    end
  end

  assign npc         = npc_q;
  assign nnpc        = nnpc_q;
  assign redir_vld   = redir_q;
  assign shadow_sel  = priv;
  assign exc_addr    = exc_q;
  assign irq_recheck = recheck_q;

  AST_NNPC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> (nnpc == npc + STEP)); // R7

  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> (npc == $past(exc_addr)) && (exc_addr == $past(exc_addr))); // R8

  AST_RECHECK_WITH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_recheck |-> redir_vld); // R8

  AST_USER_RET_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_req && !shadow_sel && !fault_req && !boot_q) |=> (shadow_sel && !irq_recheck)); // R9

  AST_FAULT_BEATS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req && fault_kind != 3'd0 && eret_req) |=> !irq_recheck && shadow_sel); // R10

  AST_NULL_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req && fault_kind == 3'd0 && !eret_req && !boot_q) |=> !redir_vld && $stable(exc_addr)); // R11

endmodule

// File: tb/trap_sequencer_tb.sv
module trap_sequencer_tb_top;

  localparam int AW = 32;
  localparam logic [AW-1:0] BASE = 32'h0001_0000;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] pal_base;
  logic [AW-1:0] cur_pc;
  logic          fault_req;
  logic [2:0]    fault_kind;
  logic          eret_req;
  logic [AW-1:0] npc;
  logic [AW-1:0] nnpc;
  logic          redir_vld;
  logic          shadow_sel;
  logic [AW-1:0] exc_addr;
  logic          irq_recheck;

  int n_cmp;
  int n_bad;
  bit done;

  trap_sequencer #(.ADDR_W(AW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pal_base    (pal_base),
    .cur_pc      (cur_pc),
    .fault_req   (fault_req),
    .fault_kind  (fault_kind),
    .eret_req    (eret_req),
    .npc         (npc),
    .nnpc        (nnpc),
    .redir_vld   (redir_vld),
    .shadow_sel  (shadow_sel),
    .exc_addr    (exc_addr),
    .irq_recheck (irq_recheck)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_redirect(input string req, input logic [AW-1:0] exp_pc, input logic exp_sh, input logic [AW-1:0] exp_exc, input logic exp_rc);
    chk(req, "redir_vld", AW'(redir_vld), AW'(1));
    chk(req, "npc", npc, exp_pc);
    chk("R7", "nnpc", nnpc, exp_pc + 32'd4);
    chk(req, "shadow_sel", AW'(shadow_sel), AW'(exp_sh));
    chk(req, "exc_addr", exc_addr, exp_exc);
    chk(req, "irq_recheck", AW'(irq_recheck), AW'(exp_rc));
  endtask

  task automatic post_fault(input logic [2:0] k, input logic [AW-1:0] pc, input logic with_ret);
    @(negedge clk);
    fault_req  = 1'b1;
    fault_kind = k;
    cur_pc     = pc;
    eret_req   = with_ret;
    @(negedge clk);
    fault_req  = 1'b0;
    eret_req   = 1'b0;
  endtask

  task automatic post_ret(input logic [AW-1:0] pc);
    @(negedge clk);
    eret_req = 1'b1;
    cur_pc   = pc;
    @(negedge clk);
    eret_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "shadow_sel", AW'(shadow_sel), AW'(1));
    chk("R1", "redir_vld", AW'(redir_vld), AW'(0));
    chk("R1", "exc_addr", exc_addr, '0);
    chk("R1", "npc", npc, '0);
    chk("R1", "irq_recheck", AW'(irq_recheck), AW'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_redirect("R1", BASE + 32'h0001, 1'b1, '0, 1'b0);
    @(negedge clk);
    chk("R2", "redir pulse width", AW'(redir_vld), AW'(0));
  endtask

  task automatic t_return_to_user(input logic [AW-1:0] exp_pc);
    post_ret(32'h0000_9999);
    chk_redirect("R8", exp_pc, 1'b0, exp_pc, 1'b1);
    @(negedge clk);
    chk("R8", "recheck pulse width", AW'(irq_recheck), AW'(0));
  endtask

  task automatic t_align_user;
    post_fault(3'd3, 32'h0000_1000, 1'b0);
    chk_redirect("R3", BASE + 32'h0301, 1'b1, 32'h0000_1000, 1'b0);
  endtask

  task automatic t_palcall_user;
    post_fault(3'd5, 32'h0000_2000, 1'b0);
    chk_redirect("R4", BASE + 32'h2001, 1'b1, 32'h0000_2004, 1'b0);
  endtask

  task automatic t_intr_nested;
    post_fault(3'd4, 32'h0001_0055, 1'b0);
    chk_redirect("R5", BASE + 32'h0101, 1'b1, 32'h0000_2004, 1'b0);
    chk("R12", "shadow kept", AW'(shadow_sel), AW'(1));
  endtask

  task automatic t_user_eret;
    post_ret(32'h0000_2004);
    chk_redirect("R9", BASE + 32'h0501, 1'b1, 32'h0000_2004, 1'b0);
  endtask

  task automatic t_intr_user;
    post_fault(3'd4, 32'h0000_3000, 1'b0);
    chk_redirect("R5", BASE + 32'h0101, 1'b1, 32'h0000_3000, 1'b0);
  endtask

  task automatic t_mchk_priv;
    post_fault(3'd2, 32'h0001_0400, 1'b0);
    chk_redirect("R3", BASE + 32'h0401, 1'b1, 32'h0001_0401, 1'b0);
    chk("R12", "shadow kept", AW'(shadow_sel), AW'(1));
  endtask

  task automatic t_return_stay_priv;
    post_ret(32'h0001_0999);
    chk_redirect("R8", 32'h0001_0401, 1'b1, 32'h0001_0401, 1'b1);
  endtask

  task automatic t_null_fault;
    post_fault(3'd0, 32'h0000_7770, 1'b0);
    chk("R11", "redir_vld", AW'(redir_vld), AW'(0));
    chk("R11", "npc", npc, 32'h0001_0401);
    chk("R11", "exc_addr", exc_addr, 32'h0001_0401);
    chk("R11", "shadow_sel", AW'(shadow_sel), AW'(1));
  endtask

  task automatic t_collision;
    post_fault(3'd6, 32'h0001_0300, 1'b1);
    chk_redirect("R10", BASE + 32'h0201, 1'b1, 32'h0001_0301, 1'b0);
  endtask

  initial begin
    n_cmp      = 0;
    n_bad      = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    pal_base   = BASE;
    cur_pc     = '0;
    fault_req  = 1'b0;
    fault_kind = 3'd0;
    eret_req   = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_return_to_user(32'h0000_0000);
    t_align_user();
    t_return_to_user(32'h0000_1000);
    t_palcall_user();
    t_intr_nested();
    t_return_to_user(32'h0000_2004);
    t_user_eret();
    t_return_to_user(32'h0000_2004);
    t_intr_user();
    t_mchk_priv();
    t_return_stay_priv();
    t_null_fault();
    t_collision();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 5000; cyc++) begin
      @(posedge clk);
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule